// File: doc/BRIEF.md
# CRTC Raster Timing Generator

This block produces the raster timing for one display head. The pixel clock drives it. Horizontal positions are counted in character cells of eight pixels, and vertical positions are counted in scanlines. Software programs the timing as encoded register values. The horizontal total carries a bias of five cells and the vertical total a bias of two lines. The blank and sync end positions are short fields that are compared only against the low bits of the running counter.

Each sync and blank span is an interval that starts on a full-width position match. It ends on the first later position whose low bits equal the short end field. The outputs are the horizontal and vertical sync with selectable polarity, a display-enable flag, a combined blank flag, the current scanline and a vertical-retrace status. Each sync can be disabled on its own for power-saving states, and a screen-off control forces display enable low. The encoded timing values are captured at frame boundaries, so a frame never mixes old and new timing.

Top module: `crtc_timing_gen`

## Requirements
- R1: A character cell lasts 8 pixel clocks. A line lasts `h_total_i + 5` cells, with cell index 0 to `h_total_i + 4`. The scanline counter steps on the last pixel clock of the last cell.
- R2: A frame lasts `v_total_i + 2` lines. `line_o` (11 bits) counts 0 to `v_total_i + 1` and then returns to 0.
- R3: The horizontal sync span becomes active on entry to the cell equal to `h_sync_start_i`. It becomes inactive on entry to the next cell whose index, modulo 32, equals `h_sync_end_i`. When both match on the same cell, the start takes priority.
- R4: The vertical sync span becomes active on entry to the line equal to `v_sync_start_i`. It becomes inactive on entry to a line whose index, modulo 16, equals `v_sync_end_i`, and the start takes priority. `vretrace_o` is 1 while this span is active, whatever the polarity and disable settings.
- R5: `blank_o` is the OR of two spans. The horizontal span starts at cell `h_blank_start_i` and ends at a cell whose index modulo 128 equals `h_blank_end_i`. The vertical span starts at line `v_blank_start_i` and ends at a line whose index modulo 256 equals `v_blank_end_i`. The start takes priority in both spans.
- R6: `disp_en_o` is 1 exactly when the cell index is at most `h_disp_end_i`, the line is at most `v_disp_end_i`, and `screen_off_i` is 0.
- R7: A polarity input of 1 makes that sync active-low. Each sync output equals its active state XOR its polarity bit.
- R8: While `h_sync_off_i` (or `v_sync_off_i`) is 1, that sync output holds its inactive level, which is equal to its polarity bit. The setting takes effect immediately and leaves `vretrace_o` unchanged.
- R9: Timing values are captured on the first clock after reset and on each clock where the last pixel of the last line wraps to line 0. Changes at any other time have no effect until the next capture.
- R10: During reset and before the first capture, `line_o` is 0, both spans are inactive (each sync output equals its polarity bit), and `disp_en_o`, `blank_o` and `vretrace_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| h_total_i | input | 9 | Line length in cells minus 5 |
| h_disp_end_i | input | 9 | Last displayed cell |
| h_blank_start_i | input | 9 | Cell where horizontal blank begins |
| h_blank_end_i | input | 7 | Low 7 bits of the cell where horizontal blank ends |
| h_sync_start_i | input | 9 | Cell where horizontal sync begins |
| h_sync_end_i | input | 5 | Low 5 bits of the cell where horizontal sync ends |
| v_total_i | input | 11 | Frame length in lines minus 2 |
| v_disp_end_i | input | 11 | Last displayed line |
| v_blank_start_i | input | 11 | Line where vertical blank begins |
| v_blank_end_i | input | 8 | Low 8 bits of the line where vertical blank ends |
| v_sync_start_i | input | 11 | Line where vertical sync begins |
| v_sync_end_i | input | 4 | Low 4 bits of the line where vertical sync ends |
| h_sync_neg_i | input | 1 | 1: horizontal sync active low |
| v_sync_neg_i | input | 1 | 1: vertical sync active low |
| h_sync_off_i | input | 1 | 1: hold horizontal sync inactive |
| v_sync_off_i | input | 1 | 1: hold vertical sync inactive |
| screen_off_i | input | 1 | 1: force display enable low |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| disp_en_o | output | 1 | Display enable |
| blank_o | output | 1 | Horizontal or vertical blank active |
| line_o | output | 11 | Current scanline |
| vretrace_o | output | 1 | Vertical retrace status |

## Verification
Two functions can fall in the same cycle. A span's start position can match in the same cycle as its truncated end field. The capture of new timing values can also coincide with the evaluation of the first cell and line of the new frame. Directed configurations set the start and end fields to the same low bits, so the bench can confirm that the start wins and the span then runs until a later alias of the end value. Randomly timed register writes land mid-frame and on frame edges, and a cycle-level reference model, which adopts new values only at the wrap, judges every output on every clock.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  parameter int DOT_BITS = 3;
  parameter int H_W      = 9;
  parameter int HSE_W    = 5;
  parameter int HBE_W    = 7;
  parameter int V_W      = 11;
  parameter int VSE_W    = 4;
  parameter int VBE_W    = 8;
  parameter int H_BIAS   = 5;
  parameter int V_BIAS   = 2;
  localparam int CH_W    = H_W + 1;
  localparam int LN_W    = V_W + 1;

  typedef struct packed {
    logic [H_W-1:0]   h_total;
    logic [H_W-1:0]   h_disp_end;
    logic [H_W-1:0]   h_blank_start;
    logic [HBE_W-1:0] h_blank_end;
    logic [H_W-1:0]   h_sync_start;
    logic [HSE_W-1:0] h_sync_end;
    logic [V_W-1:0]   v_total;
    logic [V_W-1:0]   v_disp_end;
    logic [V_W-1:0]   v_blank_start;
    logic [VBE_W-1:0] v_blank_end;
    logic [V_W-1:0]   v_sync_start;
    logic [VSE_W-1:0] v_sync_end;
  } crtc_regs_t;
endpackage

// File: rtl/crtc_shadow.sv
module crtc_shadow import crtc_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_wrap_i,
  input  crtc_regs_t regs_i,
  output logic       loaded_o,
  output logic       load_o,
  output crtc_regs_t shadow_o,
  output crtc_regs_t eff_o
);
  logic       loaded_q;
  crtc_regs_t shadow_q;

  assign load_o = ~loaded_q | frame_wrap_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loaded_q <= 1'b0;
      shadow_q <= '0;
    end else begin
      loaded_q <= 1'b1;
      if (load_o) shadow_q <= regs_i;
    end
  end

  // new values apply to span evaluation on the capture edge itself
  assign eff_o    = load_o ? regs_i : shadow_q;
  assign shadow_o = shadow_q;
  assign loaded_o = loaded_q;
endmodule

// File: rtl/crtc_h_count.sv
module crtc_h_count import crtc_pkg::*; (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic [CH_W-1:0]     last_char_i,
  output logic [DOT_BITS-1:0] dot_o,
  output logic [CH_W-1:0]     char_o,
  output logic [CH_W-1:0]     char_next_o,
  output logic                char_adv_o,
  output logic                char_wrap_o
);
  logic [DOT_BITS-1:0] dot_q;
  logic [CH_W-1:0]     char_q;

  assign char_adv_o  = run_i & (&dot_q);
  assign char_wrap_o = char_adv_o & (char_q == last_char_i);

  always_comb begin
    char_next_o = char_q;
    if (char_adv_o) char_next_o = char_wrap_o ? '0 : char_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dot_q  <= '0;
      char_q <= '0;
    end else if (run_i) begin
      dot_q  <= dot_q + 1'b1;
      char_q <= char_next_o;
    end
  end

  assign dot_o  = dot_q;
  assign char_o = char_q;
endmodule

// File: rtl/crtc_v_count.sv
module crtc_v_count import crtc_pkg::*; (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            step_i,
  input  logic [LN_W-1:0] last_line_i,
  output logic [LN_W-1:0] line_o,
  output logic [LN_W-1:0] line_next_o,
  output logic            frame_wrap_o
);
  logic [LN_W-1:0] line_q;

  assign frame_wrap_o = step_i & (line_q == last_line_i);

  always_comb begin
    line_next_o = line_q;
    if (step_i) line_next_o = frame_wrap_o ? '0 : line_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= '0;
    else         line_q <= line_next_o;
  end

  assign line_o = line_q;
endmodule

// File: rtl/crtc_span.sv
module crtc_span #(
  parameter int POS_W   = 10,
  parameter int START_W = 9,
  parameter int END_W   = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               upd_i,
  input  logic [POS_W-1:0]   pos_i,
  input  logic [START_W-1:0] start_i,
  input  logic [END_W-1:0]   end_i,
  output logic               active_o
);
  logic act_q;
  logic hit_start, hit_end;

  assign hit_start = (pos_i == POS_W'(start_i));
  assign hit_end   = (pos_i[END_W-1:0] == end_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  act_q <= 1'b0;
    else if (upd_i && hit_start)  act_q <= 1'b1;
    else if (upd_i && hit_end)    act_q <= 1'b0;
  end

  assign active_o = act_q;
endmodule

// File: rtl/crtc_timing_gen.sv
module crtc_timing_gen import crtc_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [H_W-1:0]   h_total_i,
  input  logic [H_W-1:0]   h_disp_end_i,
  input  logic [H_W-1:0]   h_blank_start_i,
  input  logic [HBE_W-1:0] h_blank_end_i,
  input  logic [H_W-1:0]   h_sync_start_i,
  input  logic [HSE_W-1:0] h_sync_end_i,
  input  logic [V_W-1:0]   v_total_i,
  input  logic [V_W-1:0]   v_disp_end_i,
  input  logic [V_W-1:0]   v_blank_start_i,
  input  logic [VBE_W-1:0] v_blank_end_i,
  input  logic [V_W-1:0]   v_sync_start_i,
  input  logic [VSE_W-1:0] v_sync_end_i,
  input  logic             h_sync_neg_i,
  input  logic             v_sync_neg_i,
  input  logic             h_sync_off_i,
  input  logic             v_sync_off_i,
  input  logic             screen_off_i,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             disp_en_o,
  output logic             blank_o,
  output logic [V_W-1:0]   line_o,
  output logic             vretrace_o
);
  crtc_regs_t          regs_in, sh_q, eff;
  logic                loaded_q, load;
  logic [DOT_BITS-1:0] dot_q;
  logic [CH_W-1:0]     char_q, char_next;
  logic                char_adv, char_wrap;
  logic [LN_W-1:0]     line_q, line_next;
  logic                frame_wrap;
  logic                h_upd, v_upd;
  logic                hs_act, hb_act, vs_act, vb_act;
  logic [CH_W-1:0]     last_char;
  logic [LN_W-1:0]     last_line;

  assign regs_in = '{h_total: h_total_i, h_disp_end: h_disp_end_i,
                     h_blank_start: h_blank_start_i, h_blank_end: h_blank_end_i,
                     h_sync_start: h_sync_start_i, h_sync_end: h_sync_end_i,
                     v_total: v_total_i, v_disp_end: v_disp_end_i,
                     v_blank_start: v_blank_start_i, v_blank_end: v_blank_end_i,
                     v_sync_start: v_sync_start_i, v_sync_end: v_sync_end_i};

  // biased totals: last index = total register + bias - 1
  assign last_char = CH_W'(sh_q.h_total) + CH_W'(H_BIAS - 1);
  assign last_line = LN_W'(sh_q.v_total) + LN_W'(V_BIAS - 1);

  crtc_shadow u_shadow (
    .clk_i, .rst_ni, .frame_wrap_i(frame_wrap), .regs_i(regs_in),
    .loaded_o(loaded_q), .load_o(load), .shadow_o(sh_q), .eff_o(eff)
  );

  crtc_h_count u_hcnt (
    .clk_i, .rst_ni, .run_i(loaded_q), .last_char_i(last_char),
    .dot_o(dot_q), .char_o(char_q), .char_next_o(char_next),
    .char_adv_o(char_adv), .char_wrap_o(char_wrap)
  );

  crtc_v_count u_vcnt (
    .clk_i, .rst_ni, .step_i(char_wrap), .last_line_i(last_line),
    .line_o(line_q), .line_next_o(line_next), .frame_wrap_o(frame_wrap)
  );

  assign h_upd = ~loaded_q | char_adv;
  assign v_upd = ~loaded_q | char_wrap;

  crtc_span #(.POS_W(CH_W), .START_W(H_W), .END_W(HSE_W)) u_hsync (
    .clk_i, .rst_ni, .upd_i(h_upd), .pos_i(char_next),
    .start_i(eff.h_sync_start), .end_i(eff.h_sync_end), .active_o(hs_act)
  );

  crtc_span #(.POS_W(CH_W), .START_W(H_W), .END_W(HBE_W)) u_hblank (
    .clk_i, .rst_ni, .upd_i(h_upd), .pos_i(char_next),
    .start_i(eff.h_blank_start), .end_i(eff.h_blank_end), .active_o(hb_act)
  );

  crtc_span #(.POS_W(LN_W), .START_W(V_W), .END_W(VSE_W)) u_vsync (
    .clk_i, .rst_ni, .upd_i(v_upd), .pos_i(line_next),
    .start_i(eff.v_sync_start), .end_i(eff.v_sync_end), .active_o(vs_act)
  );

  crtc_span #(.POS_W(LN_W), .START_W(V_W), .END_W(VBE_W)) u_vblank (
    .clk_i, .rst_ni, .upd_i(v_upd), .pos_i(line_next),
    .start_i(eff.v_blank_start), .end_i(eff.v_blank_end), .active_o(vb_act)
  );

  assign hsync_o    = (hs_act & ~h_sync_off_i) ^ h_sync_neg_i;
  assign vsync_o    = (vs_act & ~v_sync_off_i) ^ v_sync_neg_i;
  assign vretrace_o = vs_act;
  assign blank_o    = hb_act | vb_act;
  assign disp_en_o  = loaded_q & ~screen_off_i &
                      (char_q <= CH_W'(sh_q.h_disp_end)) &
                      (line_q <= LN_W'(sh_q.v_disp_end));
  assign line_o     = line_q[V_W-1:0];
endmodule

// File: rtl/crtc_timing_chk.sv
module crtc_timing_chk import crtc_pkg::*; (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [V_W-1:0]      line_o,
  input logic                hsync_o,
  input logic                h_sync_off_i,
  input logic                h_sync_neg_i,
  input logic                disp_en_o,
  input logic                screen_off_i,
  input logic [DOT_BITS-1:0] dot_q,
  input logic [CH_W-1:0]     char_q,
  input logic                hs_act,
  input crtc_regs_t          sh_q,
  input logic                loaded_q
);
  assert_char_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_q <= CH_W'(sh_q.h_total) + CH_W'(H_BIAS - 1));

  assert_line_edge_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_o != $past(line_o)) |-> (char_q == '0 && dot_q == '0));

  assert_line_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_o != $past(line_o)) |-> (line_o == $past(line_o) + 1'b1 || line_o == '0));

  assert_span_align_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_act != $past(hs_act)) |-> (dot_q == '0));

  assert_scr_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    screen_off_i |-> !disp_en_o);

  assert_hsync_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_sync_off_i |-> (hsync_o == h_sync_neg_i));

  assert_shadow_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sh_q) |-> (dot_q == '0 && char_q == '0 && line_o == '0));

  assert_pre_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loaded_q |-> !disp_en_o);
endmodule

bind crtc_timing_gen crtc_timing_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .line_o(line_o), .hsync_o(hsync_o),
  .h_sync_off_i(h_sync_off_i), .h_sync_neg_i(h_sync_neg_i),
  .disp_en_o(disp_en_o), .screen_off_i(screen_off_i),
  .dot_q(dot_q), .char_q(char_q), .hs_act(hs_act), .sh_q(sh_q), .loaded_q(loaded_q)
);

// File: tb/crtc_timing_gen_bench.sv
module crtc_timing_gen_bench;
  import crtc_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  crtc_regs_t cfg;
  logic hneg = 0, vneg = 0, hoff = 0, voff = 0, scr = 0;
  logic hsync, vsync, disp_en, blank, vretrace;
  logic [V_W-1:0] line;

  crtc_timing_gen u_crtc_timing_gen (
    .clk_i(clk), .rst_ni(rst_n),
    .h_total_i(cfg.h_total), .h_disp_end_i(cfg.h_disp_end),
    .h_blank_start_i(cfg.h_blank_start), .h_blank_end_i(cfg.h_blank_end),
    .h_sync_start_i(cfg.h_sync_start), .h_sync_end_i(cfg.h_sync_end),
    .v_total_i(cfg.v_total), .v_disp_end_i(cfg.v_disp_end),
    .v_blank_start_i(cfg.v_blank_start), .v_blank_end_i(cfg.v_blank_end),
    .v_sync_start_i(cfg.v_sync_start), .v_sync_end_i(cfg.v_sync_end),
    .h_sync_neg_i(hneg), .v_sync_neg_i(vneg), .h_sync_off_i(hoff),
    .v_sync_off_i(voff), .screen_off_i(scr),
    .hsync_o(hsync), .vsync_o(vsync), .disp_en_o(disp_en), .blank_o(blank),
    .line_o(line), .vretrace_o(vretrace)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic bit span_step(bit a, int pos, int st, int en, int modv);
    if (pos == st) return 1'b1;
    if ((pos % modv) == en) return 1'b0;
    return a;
  endfunction

  // reference model: pixel/line positions, captured timing, span states
  bit m_loaded, m_hs, m_hb, m_vs, m_vb;
  int m_px, m_ln;
  crtc_regs_t m_sh;

  always @(posedge clk or negedge rst_n) begin : model
    int ppl, lpf, npx, nln;
    bit lstep, fwrap;
    crtc_regs_t sh;
    if (!rst_n) begin
      m_loaded <= 0; m_px <= 0; m_ln <= 0;
      m_hs <= 0; m_hb <= 0; m_vs <= 0; m_vb <= 0; m_sh <= '0;
    end else if (!m_loaded) begin
      m_loaded <= 1; m_sh <= cfg;
      m_hs <= span_step(m_hs, 0, int'(cfg.h_sync_start), int'(cfg.h_sync_end), 32);
      m_hb <= span_step(m_hb, 0, int'(cfg.h_blank_start), int'(cfg.h_blank_end), 128);
      m_vs <= span_step(m_vs, 0, int'(cfg.v_sync_start), int'(cfg.v_sync_end), 16);
      m_vb <= span_step(m_vb, 0, int'(cfg.v_blank_start), int'(cfg.v_blank_end), 256);
    end else begin
      ppl = 8 * (int'(m_sh.h_total) + 5);
      lpf = int'(m_sh.v_total) + 2;
      npx = m_px + 1; nln = m_ln; lstep = 0; fwrap = 0;
      if (npx == ppl) begin
        npx = 0; lstep = 1; nln = m_ln + 1;
        if (nln == lpf) begin nln = 0; fwrap = 1; end
      end
      sh = fwrap ? cfg : m_sh;
      if (m_px % 8 == 7) begin
        m_hs <= span_step(m_hs, npx / 8, int'(sh.h_sync_start), int'(sh.h_sync_end), 32);
        m_hb <= span_step(m_hb, npx / 8, int'(sh.h_blank_start), int'(sh.h_blank_end), 128);
      end
      if (lstep) begin
        m_vs <= span_step(m_vs, nln, int'(sh.v_sync_start), int'(sh.v_sync_end), 16);
        m_vb <= span_step(m_vb, nln, int'(sh.v_blank_start), int'(sh.v_blank_end), 256);
      end
      m_px <= npx; m_ln <= nln; m_sh <= sh;
    end
  end

  task automatic check_all();
    int ed;
    chk("R2", "line_o", int'(line), m_ln);
    chk("R3/R7/R8", "hsync_o", int'(hsync), int'((m_hs & ~hoff) ^ hneg));
    chk("R4/R7/R8", "vsync_o", int'(vsync), int'((m_vs & ~voff) ^ vneg));
    chk("R4", "vretrace_o", int'(vretrace), int'(m_vs));
    chk("R5", "blank_o", int'(blank), int'(m_hb | m_vb));
    ed = int'(m_loaded && !scr && (m_px / 8 <= int'(m_sh.h_disp_end)) &&
              (m_ln <= int'(m_sh.v_disp_end)));
    chk("R1/R6/R9", "disp_en_o", int'(disp_en), ed);
  endtask

  function automatic int rnd(int lo, int hi);
    return lo + int'($urandom % 32'(hi - lo + 1));
  endfunction

  task automatic rand_cfg();
    int ht, vt;
    ht = rnd(1, 20); vt = rnd(2, 16);
    cfg.h_total       = H_W'(ht);
    cfg.h_disp_end    = H_W'(rnd(0, ht + 4));
    cfg.h_blank_start = H_W'(rnd(0, ht + 4));
    cfg.h_blank_end   = HBE_W'(rnd(0, 127));
    cfg.h_sync_start  = H_W'(rnd(0, ht + 4));
    cfg.h_sync_end    = HSE_W'(rnd(0, 31));
    cfg.v_total       = V_W'(vt);
    cfg.v_disp_end    = V_W'(rnd(0, vt + 1));
    cfg.v_blank_start = V_W'(rnd(0, vt + 1));
    cfg.v_blank_end   = VBE_W'(rnd(0, 255));
    cfg.v_sync_start  = V_W'(rnd(0, vt + 1));
    cfg.v_sync_end    = VSE_W'(rnd(0, 15));
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_all();
      if (i % 250 == 249) begin
        hneg = 1'($urandom); vneg = 1'($urandom);
        hoff = ($urandom % 4) == 0; voff = ($urandom % 4) == 0;
        scr  = ($urandom % 5) == 0;
      end
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog: actual %0d expected below %0d", cyc, 200000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    // directed: start and truncated end alias the same cell/line (R3, R4)
    cfg = '0;
    cfg.h_total = 9'd3; cfg.h_disp_end = 9'd5; cfg.h_blank_start = 9'd5;
    cfg.h_blank_end = 7'd7; cfg.h_sync_start = 9'd6; cfg.h_sync_end = 5'd6;
    cfg.v_total = 11'd10; cfg.v_disp_end = 11'd7; cfg.v_blank_start = 11'd8;
    cfg.v_blank_end = 8'd11; cfg.v_sync_start = 11'd9; cfg.v_sync_end = 4'd9;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "line_o in reset", int'(line), 0);
    chk("R10", "hsync_o in reset", int'(hsync), 0);
    chk("R10", "vsync_o in reset", int'(vsync), 0);
    chk("R10", "disp_en_o in reset", int'(disp_en), 0);
    chk("R10", "blank_o in reset", int'(blank), 0);
    chk("R10", "vretrace_o in reset", int'(vretrace), 0);
    rst_n = 1'b1;
    run(2000);
    // directed: end matches on low 5 bits only, well after start (R3)
    cfg.h_total = 9'd40; cfg.h_disp_end = 9'd31; cfg.h_blank_start = 9'd32;
    cfg.h_blank_end = 7'd44; cfg.h_sync_start = 9'd2; cfg.h_sync_end = 5'd1;
    cfg.v_total = 11'd4; cfg.v_disp_end = 11'd3; cfg.v_blank_start = 11'd4;
    cfg.v_blank_end = 8'd5; cfg.v_sync_start = 11'd4; cfg.v_sync_end = 4'd5;
    run(5000);
    // random timing writes land mid-frame and at frame edges (R9)
    for (int k = 0; k < 28; k++) begin
      rand_cfg();
      run(rnd(1500, 2200));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule